// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides the outcome of a relative branch and computes the program counter that follows it. Each cycle that an instruction is presented, it receives a 4-bit condition selector (the low nibble of the branch opcode), the four condition flags, the address of the byte just after the branch instruction, and a displacement. The displacement is either 8 or 16 bits wide, depending on whether the branch is short or long.

The sixteen conditions come in true/false pairs over eight flag tests. An even selector is a test in its positive sense, and the odd selector above it is that same test negated. A taken branch adds the displacement to the next-instruction address. A short displacement is sign-extended first. A branch that is not taken passes the next-instruction address through. The decision and the resulting address are registered and appear one clock after the request.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid_o` and `taken_o` become 0 and `target_o` becomes 0000h.
- R2: An accepted request (`valid_i` high at an edge) drives `out_valid_o` high and updates `taken_o`/`target_o` after that edge. With `valid_i` low, `out_valid_o` is 0 and `taken_o`/`target_o` keep their values.
- R3: Selector 0h is always taken and selector 1h is never taken, whatever the flags are.
- R4: Selector 2h (unsigned higher) is taken when C OR Z is 0. Selector 3h (lower or same) is taken when C OR Z is 1.
- R5: Single-flag tests: 4h taken when C=0, 5h when C=1, 6h when Z=0, 7h when Z=1, 8h when V=0, 9h when V=1, Ah when N=0, Bh when N=1.
- R6: Signed tests: Ch taken when N XOR V is 0, Dh when it is 1, Eh when (N XOR V) OR Z is 0, Fh when it is 1.
- R7: For every flag combination, selectors 2k and 2k+1 give opposite decisions.
- R8: With `long_i`=0, only `offset_i[7:0]` is used. It is sign-extended to 16 bits, and bits 15:8 have no effect. Examples: next address E102h with offset 08h gives E10Ah; E10Ah with FAh gives E104h.
- R9: With `long_i`=1, the full 16-bit offset is added, and the sum wraps modulo 2^16.
- R10: A branch that is not taken outputs `next_pc_i` unchanged as `target_o`.
- R11: `flags_i` bit order is {N, Z, V, C} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present this cycle |
| cond_i | input | 4 | Condition selector (low opcode nibble) |
| long_i | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| flags_i | input | 4 | Condition flags {N, Z, V, C} |
| next_pc_i | input | 16 | Address of the byte after the branch |
| offset_i | input | 16 | Displacement; low 8 bits only when short |
| out_valid_o | output | 1 | Result registered this cycle |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |

## Verification
The hardest cases to reach are the signed tests where N and V disagree. A one-sided flag sweep sets only one of them and so never produces that situation. The bench therefore crosses all sixteen selectors with all sixteen flag patterns.

The address carry across the 16-bit boundary is the other corner. It is reached by placing the next-instruction address just below FFFFh and just above 0000h, and applying positive and negative displacements of both widths. Garbage is loaded into the unused upper offset byte of short branches, to show that those bits are ignored.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned SHORT_W = 8;

    typedef enum logic [3:0] {
        SEL_ALWAYS = 4'h0, SEL_NEVER = 4'h1,
        SEL_HI     = 4'h2, SEL_LS    = 4'h3,
        SEL_CC     = 4'h4, SEL_CS    = 4'h5,
        SEL_NE     = 4'h6, SEL_EQ    = 4'h7,
        SEL_VC     = 4'h8, SEL_VS    = 4'h9,
        SEL_PL     = 4'hA, SEL_MI    = 4'hB,
        SEL_GE     = 4'hC, SEL_LT    = 4'hD,
        SEL_GT     = 4'hE, SEL_LE    = 4'hF
    } cond_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Eight positive-sense tests; index = selector[3:1]
    function automatic logic [7:0] base_tests(ccr_t f);
        logic [7:0] t;
        t[0] = 1'b1;
        t[1] = ~(f.c | f.z);
        t[2] = ~f.c;
        t[3] = ~f.z;
        t[4] = ~f.v;
        t[5] = ~f.n;
        t[6] = ~(f.n ^ f.v);
        t[7] = ~((f.n ^ f.v) | f.z);
        return t;
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  cond_sel_e sel_i,
    input  ccr_t      ccr_i,
    output logic      take_o
);
    logic [7:0] tests;
    logic       pick;

    always_comb begin
        tests  = base_tests(ccr_i);
        pick   = tests[sel_i[3:1]];
        take_o = pick ^ sel_i[0];
    end
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 8
) (
    input  logic          long_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] disp_i,
    output logic [AW-1:0] sum_o
);
    localparam int unsigned EXT_W = AW - SW;

    logic [AW-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            always_comb
                disp_ext = long_i ? disp_i
                                  : {{EXT_W{disp_i[SW-1]}}, disp_i[SW-1:0]};
        end else begin : g_same
            always_comb disp_ext = disp_i;
        end
    endgenerate

    always_comb sum_o = base_i + disp_ext;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SW = SHORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [3:0]    cond_i,
    input  logic          long_i,
    input  logic [3:0]    flags_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic [AW-1:0] offset_i,
    output logic          out_valid_o,
    output logic          taken_o,
    output logic [AW-1:0] target_o
);
    cond_sel_e     sel;
    ccr_t          ccr;
    logic          take_w;
    logic [AW-1:0] sum_w;
    logic [AW-1:0] next_w;

    always_comb begin
        sel = cond_sel_e'(cond_i);
        ccr = ccr_t'(flags_i);
    end

    br_cond_eval u_eval (
        .sel_i  (sel),
        .ccr_i  (ccr),
        .take_o (take_w)
    );

    br_target_add #(.AW(AW), .SW(SW)) u_add (
        .long_i (long_i),
        .base_i (next_pc_i),
        .disp_i (offset_i),
        .sum_o  (sum_w)
    );

    always_comb next_w = take_w ? sum_w : next_pc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            target_o    <= '0;
        end else begin
            out_valid_o <= valid_i;
            if (valid_i) begin
                taken_o  <= take_w;
                target_o <= next_w;
            end
        end
    end

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> out_valid_o);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!out_valid_o && $stable(taken_o) && $stable(target_o)));

    a_r3_always: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == 4'h0) |=> taken_o);

    a_r3_never: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == 4'h1) |=> !taken_o);

    a_r4_hi_blocked: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == 4'h2 && (flags_i[0] | flags_i[2])) |=> !taken_o);

    a_r10_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !take_w) |=> (target_o == $past(next_pc_i)));

    a_r8_short_reach: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !long_i) |=>
            (((target_o - $past(next_pc_i)) <= AW'(127)) ||
             ((target_o - $past(next_pc_i)) >= AW'(2**AW - 128))));
endmodule

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  cond_i;
    logic        long_i;
    logic [3:0]  flags_i;
    logic [15:0] next_pc_i;
    logic [15:0] offset_i;
    logic        out_valid_o;
    logic        taken_o;
    logic [15:0] target_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    br_resolve u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i),
        .long_i(long_i), .flags_i(flags_i), .next_pc_i(next_pc_i),
        .offset_i(offset_i), .out_valid_o(out_valid_o),
        .taken_o(taken_o), .target_o(target_o)
    );

    // Reference decision, written from the requirement text (R3..R6, R11)
    function automatic bit ref_take(input logic [3:0] sel, input logic [3:0] f);
        bit n, z, v, c;
        {n, z, v, c} = f;
        case (sel)
            4'h0: return 1;
            4'h1: return 0;
            4'h2: return (c == 0) && (z == 0);
            4'h3: return (c == 1) || (z == 1);
            4'h4: return c == 0;
            4'h5: return c == 1;
            4'h6: return z == 0;
            4'h7: return z == 1;
            4'h8: return v == 0;
            4'h9: return v == 1;
            4'hA: return n == 0;
            4'hB: return n == 1;
            4'hC: return n == v;
            4'hD: return n != v;
            4'hE: return (n == v) && (z == 0);
            default: return (n != v) || (z == 1);
        endcase
    endfunction

    function automatic logic [15:0] ref_target(input bit tk, input bit lg,
                                               input logic [15:0] pc,
                                               input logic [15:0] off);
        int signed d;
        if (!tk) return pc;
        d = lg ? int'(off) : int'($signed(off[7:0]));
        return 16'(int'(pc) + d);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request and check the registered result one cycle later
    task automatic apply(input logic [3:0] sel, input bit lg, input logic [3:0] f,
                         input logic [15:0] pc, input logic [15:0] off,
                         input string tag);
        bit          tk;
        logic [15:0] tg;
        @(negedge clk);
        valid_i = 1'b1; cond_i = sel; long_i = lg; flags_i = f;
        next_pc_i = pc; offset_i = off;
        @(negedge clk);
        tk = ref_take(sel, f);
        tg = ref_target(tk, lg, pc, off);
        chk(out_valid_o == 1'b1, {tag, " valid"}, 32'(out_valid_o), 32'(1));
        chk(taken_o == tk, {tag, " taken"}, 32'(taken_o), 32'(tk));
        chk(target_o == tg, {tag, " target"}, 32'(target_o), 32'(tg));
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b1; cond_i = 4'h0; long_i = 1'b1;
        flags_i = 4'h0; next_pc_i = 16'h1234; offset_i = 16'h0100;
        repeat (3) @(negedge clk);
        chk(out_valid_o == 0, "R1 valid", 32'(out_valid_o), 0);
        chk(taken_o == 0, "R1 taken", 32'(taken_o), 0);
        chk(target_o == 16'h0000, "R1 target", 32'(target_o), 0);
        valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep;   // R3 R4 R5 R6 R11 over all selector/flag pairs
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 16; f++)
                apply(4'(s), 1'b0, 4'(f), 16'h4000, 16'h0010, "R3-R6 sweep");
    endtask

    task automatic t_pairs;   // R7 complementary pairs
        for (int f = 0; f < 16; f++)
            for (int k = 0; k < 8; k++) begin
                bit a;
                apply(4'(2*k), 1'b0, 4'(f), 16'h2000, 16'h0004, "R7 even");
                a = taken_o;
                apply(4'(2*k+1), 1'b0, 4'(f), 16'h2000, 16'h0004, "R7 odd");
                chk(a != taken_o, "R7 complement", 32'(taken_o), 32'(!a));
            end
    endtask

    task automatic t_short;   // R8
        apply(4'h0, 1'b0, 4'h0, 16'hE102, 16'h0008, "R8 fwd");
        chk(target_o == 16'hE10A, "R8 E10A", 32'(target_o), 32'hE10A);
        apply(4'h0, 1'b0, 4'h0, 16'hE10A, 16'h00FA, "R8 back");
        chk(target_o == 16'hE104, "R8 E104", 32'(target_o), 32'hE104);
        apply(4'h0, 1'b0, 4'h0, 16'h1000, 16'hAB7F, "R8 upper ignored max");
        chk(target_o == 16'h107F, "R8 +127", 32'(target_o), 32'h107F);
        apply(4'h0, 1'b0, 4'h0, 16'h1000, 16'h5580, "R8 upper ignored min");
        chk(target_o == 16'h0F80, "R8 -128", 32'(target_o), 32'h0F80);
        apply(4'h0, 1'b0, 4'h0, 16'h0002, 16'h00FC, "R8 wrap low");
        chk(target_o == 16'hFFFE, "R8 wrap", 32'(target_o), 32'hFFFE);
    endtask

    task automatic t_long;    // R9
        apply(4'h0, 1'b1, 4'h0, 16'hFFF0, 16'h0020, "R9 wrap up");
        chk(target_o == 16'h0010, "R9 0010", 32'(target_o), 32'h0010);
        apply(4'h0, 1'b1, 4'h0, 16'h0010, 16'h8000, "R9 far");
        chk(target_o == 16'h8010, "R9 8010", 32'(target_o), 32'h8010);
        apply(4'h0, 1'b1, 4'h0, 16'h1000, 16'h0180, "R9 no sext");
        chk(target_o == 16'h1180, "R9 1180", 32'(target_o), 32'h1180);
    endtask

    task automatic t_fallthrough;  // R10
        apply(4'h1, 1'b1, 4'hF, 16'hBEEF, 16'h1234, "R10 never");
        chk(target_o == 16'hBEEF, "R10 pc", 32'(target_o), 32'hBEEF);
        apply(4'h7, 1'b0, 4'h0, 16'hFFFF, 16'h007F, "R10 eq false");
        chk(target_o == 16'hFFFF, "R10 pc2", 32'(target_o), 32'hFFFF);
    endtask

    task automatic t_hold;    // R2
        logic        tk;
        logic [15:0] tg;
        apply(4'h0, 1'b1, 4'h0, 16'h3000, 16'h0100, "R2 setup");
        tk = taken_o; tg = target_o;
        @(negedge clk);
        valid_i = 1'b0; cond_i = 4'h1; next_pc_i = 16'h7777; offset_i = 16'h0;
        repeat (2) @(negedge clk);
        chk(out_valid_o == 0, "R2 idle valid", 32'(out_valid_o), 0);
        chk(taken_o == tk, "R2 hold taken", 32'(taken_o), 32'(tk));
        chk(target_o == tg, "R2 hold target", 32'(target_o), 32'(tg));
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_pairs();
        t_short();
        t_long();
        t_fallthrough();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule